// File: doc/BRIEF.md
# Atomic 16-bit register access bridge

This block sits between an 8-bit processor bus and a small file of 16-bit registers: one free-running counter and two compare registers. An 8-bit bus can move only one byte per access, so a 16-bit value would normally be read or written in two separate steps. The bridge joins those two steps into one indivisible transfer by using a single holding byte that every 16-bit register shares.

Software writes the upper half first. That access only fills the holding byte. The lower-half write that follows sends the whole word, holding byte on top and bus byte below, to the addressed register in one cycle. Reads work in the opposite order. Software reads the lower half first, which returns the live low byte and at the same clock edge copies that register's upper byte into the holding byte. A later read of the counter's upper half returns the holding byte, so the two halves always come from the same instant even though the counter moves every cycle. The compare registers change only when the processor writes them, so their upper-half reads bypass the holding byte.

The counter logic and the register storage are outside the block. The bridge receives their current values and drives one write strobe per register and a shared 16-bit write word. Keeping interrupts from splitting a transfer is left to software.

Top module: `atomic16_bridge`

## Requirements
- R1: After synchronous reset the holding byte is zero, so reading the counter's upper-half address (address 1) before any other access returns 0x00.
- R2: A write to an upper-half address (odd address 2i+1) loads the bus byte into the holding byte and raises no write strobe.
- R3: A write to a lower-half address (even address 2i) raises only strobe bit i during that same cycle, with write word {holding byte, bus byte}. Register 0 is the counter, 1 is compare A, 2 is compare B.
- R4: A read of a lower-half address returns the register's current low byte in that cycle and copies the register's current high byte into the holding byte at the clock edge that ends the cycle.
- R5: A read of the counter's upper-half address returns the holding byte, not the live counter, even after the counter has advanced.
- R6: A read of a compare register's upper-half address (3 or 5) returns that register's high byte directly, whatever the holding byte contains.
- R7: Because the holding byte is shared, an upper-half write or lower-half read of another register between the two halves of a transfer replaces the byte used by that transfer.
- R8: Reading the counter low then high across a carry from the low byte into the high byte (for example 0x00FF advancing to 0x0100) returns the two halves of one value (0xFF then 0x00).
- R9: When write and read are both asserted, only the write takes effect: read data is 0x00 and the read does not load the holding byte.
- R10: Addresses at or above 2 x register count (6 and 7) raise no strobe, return 0x00 and leave the holding byte unchanged.
- R11: Read data is 0x00 in every cycle in which no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Byte address: 2i is the low half and 2i+1 the high half of register i |
| bus_wr | input | 1 | Write request for this cycle |
| bus_rd | input | 1 | Read request for this cycle |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid in the same cycle as the request |
| reg_q | input | 48 | Current register values, register i at bits 16i+15:16i |
| wr_stb | output | 3 | One-hot write strobe per 16-bit register |
| wr_data | output | 16 | Word to load into the strobed register |

## Verification
Two functions can fall into the same cycle. A lower-half read of the counter captures the upper byte at the same edge where the counter carries into that byte. A lower-half write to the counter also coincides with the counter's own increment. The bench provokes the first by loading values whose low byte is 0xFE, 0xFF, 0x00 or 0x7F and reading them back at once. It judges the pair of bytes against the value loaded, which must come back whole and never mixed with the incremented one. The second is judged by seeing the loaded word come back, not the incremented count.

// File: rtl/bridge_pkg.sv
// Package: shared types for the atomic 16-bit access bridge.
// Assumes: one bus access per cycle, decoded into exactly one kind.
package bridge_pkg;

    // Decoded kind of the bus access present in the current cycle
    typedef enum logic [2:0] {
        ACC_NONE  = 3'd0,
        ACC_WR_HI = 3'd1,
        ACC_WR_LO = 3'd2,
        ACC_RD_HI = 3'd3,
        ACC_RD_LO = 3'd4
    } acc_kind_t;

endpackage

// File: rtl/acc_decode.sv
// Module: acc_decode
// Turns the byte address and the request lines into an access kind and a
// one-hot register select. A write has priority over a read in the same
// cycle. An address past the last register decodes to ACC_NONE.
// Assumes NUM_REGS >= 2, so the address has at least two bits.
module acc_decode
    import bridge_pkg::*;
#(
    parameter int NUM_REGS = 3,
    localparam int ADDR_W  = $clog2(2 * NUM_REGS),
    localparam int IDX_W   = ADDR_W - 1
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr,
    input  logic                rd,
    output acc_kind_t           kind,
    output logic [NUM_REGS-1:0] sel
);

    logic             in_range;
    logic             is_hi;
    logic [IDX_W-1:0] idx;

    // Split the address into register index and half, and check range
    always_comb begin
        in_range = {{(32-ADDR_W){1'b0}}, addr} < 32'(2 * NUM_REGS);
        is_hi    = addr[0];
        idx      = addr[ADDR_W-1:1];
    end

    // One-hot select of the addressed register
    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            sel[i] = in_range && (32'(idx) == 32'(i));
        end
    end

    // Classify the access, write taking precedence over read
    always_comb begin
        kind = ACC_NONE;
        if (in_range) begin
            if (wr) begin
                kind = is_hi ? ACC_WR_HI : ACC_WR_LO;
            end else if (rd) begin
                kind = is_hi ? ACC_RD_HI : ACC_RD_LO;
            end
        end
    end

endmodule

// File: rtl/temp_byte.sv
// Module: temp_byte
// The single holding byte shared by all 16-bit registers. It is loaded from
// the bus on an upper-half write and from the selected register's high byte
// on a lower-half read. Otherwise it holds its value.
// Assumes sel is one-hot or zero.
module temp_byte
    import bridge_pkg::*;
#(
    parameter int NUM_REGS = 3,
    parameter int DATA_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  acc_kind_t                  kind,
    input  logic [NUM_REGS-1:0]        sel,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [NUM_REGS*DATA_W-1:0] reg_hi,
    output logic [DATA_W-1:0]          temp_q
);

    logic [DATA_W-1:0] hi_pick;

    // OR-mux the high byte of the selected register
    always_comb begin
        hi_pick = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel[i]) hi_pick = hi_pick | reg_hi[i*DATA_W +: DATA_W];
        end
    end

    // Update the holding byte on upper-half writes and lower-half reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            temp_q <= '0;
        end else begin
            case (kind)
                ACC_WR_HI: temp_q <= wdata;
                ACC_RD_LO: temp_q <= hi_pick;
                default:   temp_q <= temp_q;
            endcase
        end
    end

    AST_TEMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_NONE || kind == ACC_RD_HI || kind == ACC_WR_LO) |=> $stable(temp_q)); // R10
    AST_TEMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_WR_HI) |=> (temp_q == $past(wdata))); // R2

endmodule

// File: rtl/rd_path.sv
// Module: rd_path
// Builds the read byte. A lower-half read returns the live low byte. An
// upper-half read returns the holding byte for registers flagged in LIVE_MASK
// (they change on their own) and the register's high byte for the others.
// Anything else reads as zero.
module rd_path
    import bridge_pkg::*;
#(
    parameter int                  NUM_REGS  = 3,
    parameter int                  DATA_W    = 8,
    parameter logic [NUM_REGS-1:0] LIVE_MASK = 3'b001
) (
    input  acc_kind_t                  kind,
    input  logic [NUM_REGS-1:0]        sel,
    input  logic [NUM_REGS*DATA_W-1:0] reg_hi,
    input  logic [NUM_REGS*DATA_W-1:0] reg_lo,
    input  logic [DATA_W-1:0]          temp_q,
    output logic [DATA_W-1:0]          rdata
);

    logic [DATA_W-1:0] lo_pick;
    logic [DATA_W-1:0] hi_pick;
    logic              is_live;

    // Select both halves of the addressed register
    always_comb begin
        lo_pick = '0;
        hi_pick = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel[i]) begin
                lo_pick = lo_pick | reg_lo[i*DATA_W +: DATA_W];
                hi_pick = hi_pick | reg_hi[i*DATA_W +: DATA_W];
            end
        end
        is_live = |(sel & LIVE_MASK);
    end

    // Route the read byte according to access kind
    always_comb begin
        case (kind)
            ACC_RD_LO: rdata = lo_pick;
            ACC_RD_HI: rdata = is_live ? temp_q : hi_pick;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/atomic16_bridge.sv
// Module: atomic16_bridge (top)
// Joins 8-bit bus accesses into atomic 16-bit transfers through one shared
// holding byte. Register i occupies byte addresses 2i (low) and 2i+1 (high).
// Assumes the external register file loads wr_data at the clock edge that
// ends a cycle with its wr_stb bit high, and that reg_q shows current values.
module atomic16_bridge
    import bridge_pkg::*;
#(
    parameter int                  NUM_REGS  = 3,
    parameter int                  DATA_W    = 8,
    parameter logic [NUM_REGS-1:0] LIVE_MASK = 3'b001,
    localparam int                 ADDR_W    = $clog2(2 * NUM_REGS),
    localparam int                 WORD_W    = 2 * DATA_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [NUM_REGS*WORD_W-1:0] reg_q,
    output logic [NUM_REGS-1:0]        wr_stb,
    output logic [WORD_W-1:0]          wr_data
);

    acc_kind_t                  kind;
    logic [NUM_REGS-1:0]        sel;
    logic [DATA_W-1:0]          temp_q;
    logic [NUM_REGS*DATA_W-1:0] reg_hi;
    logic [NUM_REGS*DATA_W-1:0] reg_lo;

    // Split each 16-bit register value into its two bytes
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_split
        assign reg_lo[g*DATA_W +: DATA_W] = reg_q[g*WORD_W +: DATA_W];
        assign reg_hi[g*DATA_W +: DATA_W] = reg_q[g*WORD_W + DATA_W +: DATA_W];
    end

    acc_decode #(.NUM_REGS(NUM_REGS)) u_dec (
        .addr (bus_addr),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .kind (kind),
        .sel  (sel)
    );

    temp_byte #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_temp (
        .clk    (clk),
        .rst_n  (rst_n),
        .kind   (kind),
        .sel    (sel),
        .wdata  (bus_wdata),
        .reg_hi (reg_hi),
        .temp_q (temp_q)
    );

    rd_path #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .LIVE_MASK(LIVE_MASK)) u_rd (
        .kind   (kind),
        .sel    (sel),
        .reg_hi (reg_hi),
        .reg_lo (reg_lo),
        .temp_q (temp_q),
        .rdata  (bus_rdata)
    );

    // Commit strobe: only a lower-half write reaches the register file
    always_comb begin
        wr_stb  = (kind == ACC_WR_LO) ? sel : '0;
        wr_data = {temp_q, bus_wdata};
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb)); // R3
    AST_HI_WR_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[0]) |-> (wr_stb == '0)); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0)); // R11
    AST_WR_BEATS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_rd) |-> (bus_rdata == '0)); // R9
    AST_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        ({{(32-ADDR_W){1'b0}}, bus_addr} >= 32'(2 * NUM_REGS))
            |-> (wr_stb == '0 && bus_rdata == '0)); // R10

endmodule

// File: tb/tb_atomic16_bridge.sv
// Bench for atomic16_bridge: models the register file (running counter and
// two compare registers) and sweeps transfers with arithmetic expectations.
module tb_atomic16_bridge;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  bus_addr;
    logic        bus_wr;
    logic        bus_rd;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic [47:0] reg_q;
    logic [2:0]  wr_stb;
    logic [15:0] wr_data;

    logic [15:0] cnt;
    logic [15:0] cmp_a;
    logic [15:0] cmp_b;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    atomic16_bridge dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .reg_q     (reg_q),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data)
    );

    assign reg_q = {cmp_b, cmp_a, cnt};

    // External register file: free-running counter plus two compare registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            cmp_a <= '0;
            cmp_b <= '0;
        end else begin
            cnt <= wr_stb[0] ? wr_data : cnt + 16'd1;
            if (wr_stb[1]) cmp_a <= wr_data;
            if (wr_stb[2]) cmp_b <= wr_data;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bus cycle: drive after the falling edge, let outputs settle
    task automatic step(input logic wr, input logic rd, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr    = wr;
        bus_rd    = rd;
        bus_addr  = a;
        bus_wdata = d;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: idle cycle is quiet
        step(0, 0, 3'd0, 8'h00);
        check("R11 idle rdata", 32'(bus_rdata), 32'h0);
        check("R11 idle strobe", 32'(wr_stb), 32'h0);
        // R1: holding byte starts at zero
        step(0, 1, 3'd1, 8'h00);
        check("R1 temp after reset", 32'(bus_rdata), 32'h0);

        // R2 R3 R4 R6: compare register sweep
        for (int r = 1; r <= 2; r++) begin
            for (int i = 0; i < 64; i++) begin
                logic [15:0] v;
                v = 16'(i * 16'h1357 + r * 16'h0101);
                step(1, 0, 3'(2*r+1), v[15:8]);
                check("R2 no strobe on high write", 32'(wr_stb), 32'h0);
                step(1, 0, 3'(2*r), v[7:0]);
                check("R3 strobe", 32'(wr_stb), 32'(1 << r));
                check("R3 word", 32'(wr_data), 32'(v));
                step(0, 1, 3'(2*r), 8'h00);
                check("R4 compare low read", 32'(bus_rdata), 32'(v[7:0]));
                step(0, 1, 3'(2*r+1), 8'h00);
                check("R6 compare high read", 32'(bus_rdata), 32'(v[15:8]));
            end
        end

        // R4 R5 R8: counter load and coherent read across carries
        for (int h = 0; h < 256; h += 15) begin
            for (int k = 0; k < 4; k++) begin
                logic [7:0]  lo;
                logic [15:0] v;
                lo = (k == 0) ? 8'hFE : (k == 1) ? 8'hFF : (k == 2) ? 8'h00 : 8'h7F;
                v  = {8'(h), lo};
                step(1, 0, 3'd1, v[15:8]);
                step(1, 0, 3'd0, v[7:0]);
                check("R3 counter strobe", 32'(wr_stb), 32'h1);
                check("R3 counter word", 32'(wr_data), 32'(v));
                step(0, 1, 3'd0, 8'h00);
                check("R4 counter low", 32'(bus_rdata), 32'(v[7:0]));
                step(0, 1, 3'd1, 8'h00);
                check("R8 counter high coherent", 32'(bus_rdata), 32'(v[15:8]));
                step(0, 0, 3'd0, 8'h00);
                step(0, 1, 3'd1, 8'h00);
                check("R5 high read stays on snapshot", 32'(bus_rdata), 32'(v[15:8]));
            end
        end

        // R6: compare high read ignores the holding byte
        step(1, 0, 3'd3, 8'h12);
        step(1, 0, 3'd2, 8'h34);
        step(1, 0, 3'd5, 8'hAA);
        step(0, 1, 3'd3, 8'h00);
        check("R6 compare A high bypasses temp", 32'(bus_rdata), 32'h12);
        step(0, 1, 3'd1, 8'h00);
        check("R5 counter high returns temp", 32'(bus_rdata), 32'hAA);

        // R7: interleaved write corrupts the first transfer
        step(1, 0, 3'd3, 8'h12);
        step(1, 0, 3'd5, 8'h34);
        step(1, 0, 3'd2, 8'h56);
        check("R7 corrupted word", 32'(wr_data), 32'h3456);
        step(0, 1, 3'd3, 8'h00);
        check("R7 compare A high after corruption", 32'(bus_rdata), 32'h34);
        // R7: interleaved low read corrupts a counter snapshot
        step(0, 1, 3'd0, 8'h00);
        step(0, 1, 3'd2, 8'h00);
        step(0, 1, 3'd1, 8'h00);
        check("R7 counter high shows compare A byte", 32'(bus_rdata), 32'h34);

        // R9: write wins over simultaneous read
        step(1, 0, 3'd3, 8'h77);
        step(1, 1, 3'd2, 8'h01);
        check("R9 rdata during write", 32'(bus_rdata), 32'h0);
        check("R9 word", 32'(wr_data), 32'h7701);
        step(1, 1, 3'd1, 8'h66);
        step(0, 1, 3'd1, 8'h00);
        check("R9 read did not capture", 32'(bus_rdata), 32'h66);

        // R10: unmapped addresses
        step(1, 0, 3'd1, 8'h5A);
        step(1, 0, 3'd6, 8'h99);
        check("R10 no strobe at 6", 32'(wr_stb), 32'h0);
        step(1, 0, 3'd7, 8'h98);
        check("R10 no strobe at 7", 32'(wr_stb), 32'h0);
        step(0, 1, 3'd6, 8'h00);
        check("R10 rdata at 6", 32'(bus_rdata), 32'h0);
        step(0, 1, 3'd7, 8'h00);
        check("R10 rdata at 7", 32'(bus_rdata), 32'h0);
        step(0, 1, 3'd1, 8'h00);
        check("R10 temp kept", 32'(bus_rdata), 32'h5A);
        step(0, 1, 3'd2, 8'h00);
        check("R10 compare A unchanged", 32'(bus_rdata), 32'h01);

        step(0, 0, 3'd0, 8'h00);
        check("R11 final idle", 32'(bus_rdata), 32'h0);
        finish_run();
    end

endmodule